// File: doc/BRIEF.md
# Per-Processor Interrupt Controller Register Block

This block is the software-visible register file of a per-processor interrupt controller. A bus master reaches it through a plain 32-bit read/write port. The port carries a 12-bit byte offset and four byte enables. The block decodes the offset and holds the writable registers: an identification word, an 8-bit task priority, and a spurious-vector word whose bit 8 switches the whole controller on or off. It answers reads of a constant version word. It also answers reads of the in-service and request bitmaps, which the delivery logic supplies as input vectors.

A write to the end-of-interrupt offset stores nothing. Instead it raises a strobe for the delivery logic. Accesses to the four timer offsets are not handled here. They are steered out through a side port to a separate timer block, and that block's read data is returned on the bus. Reads are combinational. Writes take effect at the rising clock edge in which they are presented.

Top module: `lic_regfile`

## Requirements
- R1: After reset, the identification word reads 0, the task priority reads 0, the spurious-vector word reads 0x000001FF, `glob_en` is 1 and `cur_prio` is 0.
- R2: The version word at row 0x03 always reads 0x00050014: version 0x14 in bits 7:0 and the highest local vector-table index, 5, in bits 23:16. Writes to it are ignored.
- R3: The identification word at row 0x02 stores all 32 bits of a full write, so writing 0x05000000 reads back 0x05000000.
- R4: The task priority at row 0x08 keeps only bits 7:0 of a write and reads 0 in bits 31:8. `cur_prio` equals the stored value from the clock edge that wrote it.
- R5: The spurious-vector word at row 0x0F keeps bits 8:0 and reads 0 above them. `glob_en` follows its bit 8, so writing 0xFF clears `glob_en` and writing 0x1FF sets it again.
- R6: Rows 0x10+k and 0x20+k, for k from 0 to 7, read 32-bit word k of `ins_bits` and of `req_bits` respectively; word k is bits 32k+31 down to 32k. Writes to these rows change nothing.
- R7: A write to row 0x0B drives `eoi_pulse` high for exactly that bus cycle. It changes no register, and reads of that row return 0.
- R8: The row is `bus_off[11:4]`, and `bus_off[3:0]` is not decoded. Byte lane i of `bus_rdata` (bits 8i+7 to 8i) carries byte i of the selected register when `bus_be[i]` is 1 and reads 0 otherwise, so a read with `bus_be`=0011 returns only the low half-word.
- R9: A row not listed here reads 0, and a write to it leaves every register unchanged.
- R10: For rows 0x32, 0x38, 0x39 and 0x3E, `tmr_sel` is 1 and `tmr_idx` is 0, 1, 2 or 3 respectively. `tmr_wr`, `tmr_be` and `tmr_wdata` copy the bus, and the read data is `tmr_rdata` masked per lane as in R8. `tmr_sel` is 0 for every other access.
- R11: A write to a writable word updates only the byte lanes whose `bus_be` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_off | input | 12 | Byte offset |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ins_bits | input | 256 | In-service bitmap from delivery logic |
| req_bits | input | 256 | Request bitmap from delivery logic |
| glob_en | output | 1 | Controller enable (spurious word bit 8) |
| cur_prio | output | 8 | Current task priority |
| eoi_pulse | output | 1 | End-of-interrupt write strobe |
| tmr_sel | output | 1 | Timer register access |
| tmr_wr | output | 1 | Timer write |
| tmr_idx | output | 2 | Timer register index |
| tmr_be | output | 4 | Timer byte enables |
| tmr_wdata | output | 32 | Timer write data |
| tmr_rdata | input | 32 | Timer read data |

## Verification
The hardest cases to reach from the ports are those where lane masking meets the decode: a write with only some byte enables set must merge into a word that already holds earlier data, and a sub-word read must blank exactly the lanes that are off. The stimulus first loads the identification word with a known pattern. It then writes to a single middle lane and reads back through several enable patterns. It also reads the same register through offsets with non-zero low bits. For the bitmap rows, the bench drives distinct patterns into different words and then reads them. This shows that the word index comes from the row and not from the low offset bits.

// File: rtl/lic_pkg.sv
package lic_pkg;
  typedef enum logic [3:0] {
    RG_NONE, RG_IDENT, RG_VERS, RG_PRIO, RG_EOI, RG_SPUR, RG_INS, RG_REQ, RG_TMR
  } region_t;

  // expand byte enables into a bit mask over the data word
  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // enabled lanes take the new data, the rest keep the old word
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] m;
    m = lane_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int ROWW   = 8,
  parameter int NWORDS = 8,
  localparam int IDXW  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [ROWW-1:0] row,
  output region_t         region,
  output logic [IDXW-1:0] word_idx,
  output logic [1:0]      tmr_idx
);
  localparam int INS_BASE = 'h10;
  localparam int REQ_BASE = 'h20;

  always_comb begin
    region   = RG_NONE;
    word_idx = '0;
    tmr_idx  = 2'd0;
    if (int'(row) >= INS_BASE && int'(row) < INS_BASE + NWORDS) begin
      region   = RG_INS;
      word_idx = IDXW'(int'(row) - INS_BASE);
    end else if (int'(row) >= REQ_BASE && int'(row) < REQ_BASE + NWORDS) begin
      region   = RG_REQ;
      word_idx = IDXW'(int'(row) - REQ_BASE);
    end else begin
      case (int'(row))
        'h02: region = RG_IDENT;
        'h03: region = RG_VERS;
        'h08: region = RG_PRIO;
        'h0B: region = RG_EOI;
        'h0F: region = RG_SPUR;
        'h32: begin region = RG_TMR; tmr_idx = 2'd0; end
        'h38: begin region = RG_TMR; tmr_idx = 2'd1; end
        'h39: begin region = RG_TMR; tmr_idx = 2'd2; end
        'h3E: begin region = RG_TMR; tmr_idx = 2'd3; end
        default: region = RG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lic_core_regs.sv
module lic_core_regs
  import lic_pkg::*;
#(
  parameter logic [8:0] SPUR_RST = 9'h1FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_ident,
  input  logic        we_prio,
  input  logic        we_spur,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] ident_q,
  output logic [7:0]  prio_q,
  output logic [8:0]  spur_q
);
  logic [31:0] prio_next, spur_next;
  assign prio_next = lane_merge({24'd0, prio_q}, wdata, be);
  assign spur_next = lane_merge({23'd0, spur_q}, wdata, be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= '0;
      prio_q  <= '0;
      spur_q  <= SPUR_RST;
    end else begin
      if (we_ident) ident_q <= lane_merge(ident_q, wdata, be);
      if (we_prio)  prio_q  <= prio_next[7:0];
      if (we_spur)  spur_q  <= spur_next[8:0];
    end
  end
endmodule

// File: rtl/lic_rd_mux.sv
module lic_rd_mux
  import lic_pkg::*;
#(
  parameter int NWORDS = 8,
  parameter logic [31:0] VERS_WORD = 32'h0005_0014,
  localparam int IDXW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  region_t            region,
  input  logic [IDXW-1:0]    word_idx,
  input  logic [3:0]         be,
  input  logic [31:0]        ident_q,
  input  logic [7:0]         prio_q,
  input  logic [8:0]         spur_q,
  input  logic [32*NWORDS-1:0] ins_bits,
  input  logic [32*NWORDS-1:0] req_bits,
  input  logic [31:0]        tmr_rdata,
  output logic [31:0]        rdata
);
  logic [31:0] word;
  always_comb begin
    case (region)
      RG_IDENT: word = ident_q;
      RG_VERS:  word = VERS_WORD;
      RG_PRIO:  word = {24'd0, prio_q};
      RG_SPUR:  word = {23'd0, spur_q};
      RG_INS:   word = ins_bits[32*int'(word_idx) +: 32];
      RG_REQ:   word = req_bits[32*int'(word_idx) +: 32];
      RG_TMR:   word = tmr_rdata;
      default:  word = '0;
    endcase
  end
  assign rdata = word & lane_mask(be);
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_pkg::*;
#(
  parameter int AW       = 12,
  parameter int NVEC     = 256,
  parameter logic [7:0] VERS_NUM  = 8'h14,
  parameter logic [7:0] MAX_ENTRY = 8'd5,
  localparam int NWORDS  = NVEC / 32,
  localparam int ROWW    = AW - 4,
  localparam int IDXW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_off,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NVEC-1:0] ins_bits,
  input  logic [NVEC-1:0] req_bits,
  output logic          glob_en,
  output logic [7:0]    cur_prio,
  output logic          eoi_pulse,
  output logic          tmr_sel,
  output logic          tmr_wr,
  output logic [1:0]    tmr_idx,
  output logic [3:0]    tmr_be,
  output logic [31:0]   tmr_wdata,
  input  logic [31:0]   tmr_rdata
);
  localparam logic [31:0] VERS_WORD = {8'd0, MAX_ENTRY, 8'd0, VERS_NUM};

  region_t         region;
  logic [IDXW-1:0] word_idx;
  logic            wr_hit;
  logic [31:0]     ident_q;
  logic [7:0]      prio_q;
  logic [8:0]      spur_q;

  lic_decode #(.ROWW(ROWW), .NWORDS(NWORDS)) u_dec (
    .row(bus_off[AW-1:4]), .region(region), .word_idx(word_idx), .tmr_idx(tmr_idx)
  );

  assign wr_hit = bus_sel && bus_wr;

  lic_core_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_ident(wr_hit && region == RG_IDENT),
    .we_prio (wr_hit && region == RG_PRIO),
    .we_spur (wr_hit && region == RG_SPUR),
    .be(bus_be), .wdata(bus_wdata),
    .ident_q(ident_q), .prio_q(prio_q), .spur_q(spur_q)
  );

  lic_rd_mux #(.NWORDS(NWORDS), .VERS_WORD(VERS_WORD)) u_rd (
    .region(region), .word_idx(word_idx), .be(bus_be),
    .ident_q(ident_q), .prio_q(prio_q), .spur_q(spur_q),
    .ins_bits(ins_bits), .req_bits(req_bits), .tmr_rdata(tmr_rdata),
    .rdata(bus_rdata)
  );

  assign glob_en   = spur_q[8];
  assign cur_prio  = prio_q;
  assign eoi_pulse = wr_hit && region == RG_EOI;
  assign tmr_sel   = bus_sel && region == RG_TMR;
  assign tmr_wr    = tmr_sel && bus_wr;
  assign tmr_be    = bus_be;
  assign tmr_wdata = bus_wdata;
endmodule

// File: rtl/lic_regfile_chk.sv
module lic_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [11:0] bus_off,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        glob_en,
  input logic [7:0]  cur_prio,
  input logic        eoi_pulse,
  input logic        tmr_sel
);
  logic wr_now;
  assign wr_now = bus_sel && bus_wr;

  assert_vers_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_off[11:4] == 8'h03 && bus_be == 4'hF)
      |-> bus_rdata == 32'h0005_0014);

  assert_prio_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && bus_off[11:4] == 8'h08 && bus_be[0]) |=> cur_prio == $past(bus_wdata[7:0]));

  assert_prio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && bus_off[11:4] == 8'h08) |=> $stable(cur_prio));

  assert_enable_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_now && bus_off[11:4] == 8'h0F && bus_be[1]) |=> glob_en == $past(bus_wdata[8]));

  assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_now && bus_off[11:4] == 8'h0F) |=> $stable(glob_en));

  assert_eoi_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> (wr_now && bus_off[11:4] == 8'h0B && bus_rdata == 32'd0));

  assert_lane_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_be == 4'b0000) |-> bus_rdata == 32'd0);

  assert_tmr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_sel |-> (bus_sel && !eoi_pulse));
endmodule

bind lic_regfile lic_regfile_chk u_chk (.*);

// File: tb/lic_regfile_tb.sv
module lic_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_off = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [255:0] ins_bits = '0, req_bits = '0;
  logic        glob_en, eoi_pulse, tmr_sel, tmr_wr;
  logic [7:0]  cur_prio;
  logic [1:0]  tmr_idx;
  logic [3:0]  tmr_be;
  logic [31:0] tmr_wdata;
  logic [31:0] tmr_rdata = 32'h1357_9BDF;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lic_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_off(bus_off),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ins_bits(ins_bits), .req_bits(req_bits), .glob_en(glob_en), .cur_prio(cur_prio),
    .eoi_pulse(eoi_pulse), .tmr_sel(tmr_sel), .tmr_wr(tmr_wr), .tmr_idx(tmr_idx),
    .tmr_be(tmr_be), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench-side lane mask, written independently of the design
  function automatic logic [31:0] keep_lanes(input logic [31:0] w, input logic [3:0] be);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = w[8*i +: 8];
    return r;
  endfunction

  task automatic wr(input logic [11:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_off = off; bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] off, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_off = off; bus_be = be;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h020, 4'hF, d); check("R1 ident reset", d, 32'h0);
    rd(12'h080, 4'hF, d); check("R1 prio reset", d, 32'h0);
    rd(12'h0F0, 4'hF, d); check("R1 spur reset", d, 32'h1FF);
    check("R1 glob_en reset", {31'd0, glob_en}, 32'd1);
    check("R1 cur_prio reset", {24'd0, cur_prio}, 32'd0);
  endtask

  task automatic t_version();
    logic [31:0] d;
    wr(12'h030, 4'hF, 32'hFFFF_FFFF);
    rd(12'h030, 4'hF, d); check("R2 version word", d, 32'h0005_0014);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    wr(12'h020, 4'hF, 32'h0500_0000);
    rd(12'h020, 4'hF, d); check("R3 ident readback", d, 32'h0500_0000);
    wr(12'h020, 4'b0010, 32'hFFFF_FFFF);
    rd(12'h020, 4'hF, d); check("R11 lane-only write", d, 32'h0500_FF00);
    rd(12'h020, 4'b1000, d); check("R8 top byte read", d, 32'h0500_0000);
    rd(12'h020, 4'b0001, d); check("R8 low byte read", d, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h080, 4'hF, 32'h1234_5678);
    rd(12'h080, 4'hF, d); check("R4 prio mask", d, 32'h78);
    check("R4 cur_prio", {24'd0, cur_prio}, 32'h78);
    wr(12'h080, 4'hF, 32'h0000_00AB);
    rd(12'h080, 4'b0011, d); check("R8 half-word read", d, 32'h0000_00AB);
    rd(12'h08C, 4'hF, d); check("R8 low offset bits ignored", d, 32'h0000_00AB);
    wr(12'h080, 4'b0010, 32'h0000_0011);
    check("R11 prio lane untouched", {24'd0, cur_prio}, 32'hAB);
  endtask

  task automatic t_spur();
    logic [31:0] d;
    wr(12'h0F0, 4'hF, 32'h0000_00FF);
    rd(12'h0F0, 4'hF, d); check("R5 disable value", d, 32'hFF);
    check("R5 glob_en off", {31'd0, glob_en}, 32'd0);
    wr(12'h0F0, 4'hF, 32'hFFFF_FFFF);
    rd(12'h0F0, 4'hF, d); check("R5 upper bits zero", d, 32'h1FF);
    check("R5 glob_en on", {31'd0, glob_en}, 32'd1);
  endtask

  task automatic t_bitmaps();
    logic [31:0] d;
    rd(12'h100, 4'hF, d); check("R6 ins word0 zero", d, 32'h0);
    rd(12'h270, 4'hF, d); check("R6 req word7 zero", d, 32'h0);
    ins_bits[32*3 +: 32] = 32'hA5A5_0001;
    req_bits[32*7 +: 32] = 32'h8000_0042;
    req_bits[32*0 +: 32] = 32'h0000_0F0F;
    rd(12'h130, 4'hF, d); check("R6 ins word3", d, 32'hA5A5_0001);
    rd(12'h270, 4'hF, d); check("R6 req word7", d, 32'h8000_0042);
    rd(12'h200, 4'b0100, d); check("R8 req word0 lane2", d, keep_lanes(32'h0000_0F0F, 4'b0100));
    wr(12'h130, 4'hF, 32'h0);
    rd(12'h130, 4'hF, d); check("R6 ins write ignored", d, 32'hA5A5_0001);
    ins_bits = '0; req_bits = '0;
  endtask

  task automatic t_eoi();
    logic [31:0] d;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_off = 12'h0B0; bus_be = 4'hF; bus_wdata = 32'h0;
    #1 check("R7 eoi strobe", {31'd0, eoi_pulse}, 32'd1);
    @(posedge clk); #1; bus_sel = 0; bus_wr = 0;
    #1 check("R7 eoi strobe drops", {31'd0, eoi_pulse}, 32'd0);
    rd(12'h100, 4'hF, d); check("R7 ins stays zero", d, 32'h0);
    rd(12'h0B0, 4'hF, d); check("R7 eoi reads zero", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h040, 4'hF, 32'hDEAD_BEEF);
    rd(12'h040, 4'hF, d); check("R9 unmapped read", d, 32'h0);
    rd(12'h020, 4'hF, d); check("R9 ident unchanged", d, 32'h0500_FF00);
    rd(12'h080, 4'hF, d); check("R9 prio unchanged", d, 32'hAB);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    logic [11:0] offs [4] = '{12'h320, 12'h380, 12'h390, 12'h3E0};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_off = offs[k]; bus_be = 4'b0101; bus_wdata = 32'h0000_1000 + k;
      #1;
      check("R10 tmr_sel", {31'd0, tmr_sel}, 32'd1);
      check("R10 tmr_idx", {30'd0, tmr_idx}, k);
      check("R10 tmr_wr/be/wdata", {tmr_wdata[27:0], tmr_be}, {28'h0001_000 + 28'(k), 4'b0101});
      check("R10 tmr_wr", {31'd0, tmr_wr}, 32'd1);
      @(posedge clk); #1; bus_sel = 0; bus_wr = 0;
    end
    rd(12'h380, 4'b0011, d); check("R10 timer read masked", d, 32'h0000_9BDF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_off = 12'h330; bus_be = 4'hF;
    #1 check("R10 no tmr_sel elsewhere", {31'd0, tmr_sel}, 32'd0);
    bus_sel = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_version();
    t_ident();
    t_prio();
    t_spur();
    t_bitmaps();
    t_eoi();
    t_unmapped();
    t_timer();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule